// File: doc/BRIEF.md
# Scanning ADC Sequencer Front-End

This block sits between a byte-wide host register bus and a 32-channel, 16-bit sampling converter. The host programs a lower and an upper channel bound, an input range code and a settling time. It then starts work either by writing to the trigger register or by enabling a pacing tick that comes from outside. In single mode one trigger converts the lower-bound channel once. In scan mode one trigger walks every channel from the lower bound up to the upper bound. Each result goes into a deep result queue. An end-of-scan interrupt can be raised when the last word of a scan has been stored.

The converter is modelled at the ports. The block drives a channel number and a one-cycle start pulse. It takes the value on the sample input after a fixed number of cycles (`CONV_CYCLES`). Results are stored as raw two's-complement words. The host reads the low byte first and then the high byte, and the high-byte read removes the word from the queue. The power-on and probe readback values are fixed, so a host can use them to check that the block is present. After any change of channel bound or configuration, a readable flag reports that the analog path is still settling.

Top module: `adcseq_front`

## Requirements
- R1: After reset, offset 0x7 reads 0x80, offsets 0x8, 0x9 and 0xB read 0x00, and `irq` is low.
- R2: The bound registers at offsets 0x2 (lower) and 0x3 (upper) keep only bits 4:0. Writing 0x80 reads back 0x00, and writing 0xFF reads back 0x1F.
- R3: Offset 0x8 reads {conversion busy, config bit 2, config bit 3, 5'b0}. After writing 0x0C to offset 0xB and waiting for idle, it reads 0x60. Busy is high from the cycle after an accepted trigger until the last result is stored.
- R4: A write to offset 0x2, 0x3 or 0xB sets bit 7 of offset 0xB for exactly (20 − 5·s)·`US_CYCLES` cycles. Here s is bits 5:4 of the configuration in effect after the write. Bits 5:0 read back as written.
- R5: In single mode (offset 0x7 bit 2 = 0), a trigger converts only the lower-bound channel and stores one word.
- R6: In scan mode (offset 0x7 bit 2 = 1), a trigger converts the channels from the lower bound up to the upper bound inclusive, in ascending order, storing one word each. If the upper bound is not above the lower bound, only the lower-bound channel is converted.
- R7: Offset 0x0 reads bits 7:0 and offset 0x1 reads bits 15:8 of the oldest stored word. The word is the raw two's-complement sample, and its sign bit is not inverted. A read of offset 0x1 removes the word. With the queue empty, both offsets read 0x00.
- R8: A trigger that arrives while a conversion is busy or while the settling flag is set is ignored, and no word is stored.
- R9: With offset 0x9 bit 7 written to 1, the completion of a scan sets the pending flag (offset 0x9 bit 7 on read, and `irq`). Writing offset 0x8 with bit 3 set clears it. With the enable at 0, no flag is set.
- R10: When offset 0x9 bits 1:0 are non-zero, a `pace_tick` pulse acts as a trigger. When they are 00, `pace_tick` has no effect.
- R11: The queue holds `FIFO_DEPTH` words. Offset 0x7 reads {empty, full, 3'b0, scan enable, 2'b0}. Words that arrive while the queue is full are dropped, and the stored words are not disturbed.
- R12: Writing offset 0x7 with bit 1 set empties the queue. Bit 2 of the same write sets the scan mode.
- R13: Writing offset 0x8 with bit 5 set returns every register, the sequencer and the queue to their reset state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of offset 0x1 pops a word) |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pace_tick | input | 1 | External pacing pulse |
| adc_start | output | 1 | One-cycle pulse at the start of each conversion |
| adc_chan | output | 5 | Channel being converted |
| adc_sample | input | 16 | Converter result, taken `CONV_CYCLES` cycles after the start |
| irq | output | 1 | End-of-scan interrupt pending |

## Verification
A single conversion is run on each of the 32 channels. Because the bench converter returns a value that depends on the channel, a wrong channel select or a lost bound bit shows up in the data. Scan windows are tried across the whole range, across a short middle span, with the two bounds equal and with the bounds reversed. These cases separate the inclusive upper limit, the ascending order and the single-channel fallback. A sample whose only set bit is the sign bit shows whether any sign conversion has crept in. The queue is filled to exactly its depth, one more scan is run, and the queue is then drained. This shows that the overflow words are dropped and that the old words survive in order.

// File: rtl/adcseq_pkg.sv
// Shared register offsets, sequencer state type and settle-time helper.
package adcseq_pkg;

    localparam int SAMPLE_W = 16;

    localparam logic [3:0] OFS_DATA_LO = 4'h0;
    localparam logic [3:0] OFS_DATA_HI = 4'h1;
    localparam logic [3:0] OFS_CHAN_LO = 4'h2;
    localparam logic [3:0] OFS_CHAN_HI = 4'h3;
    localparam logic [3:0] OFS_QUEUE   = 4'h7;
    localparam logic [3:0] OFS_CTRL    = 4'h8;
    localparam logic [3:0] OFS_IRQ     = 4'h9;
    localparam logic [3:0] OFS_CFG     = 4'hB;

    typedef enum logic {SEQ_IDLE, SEQ_CONV} seq_state_t;

    // Settling length in cycles: 20, 15, 10 or 5 microseconds.
    function automatic int settle_len(input logic [1:0] sel, input int us_cycles);
        return (20 - 5 * int'(sel)) * us_cycles;
    endfunction

endpackage

// File: rtl/adcseq_fifo.sv
// Result queue: a power-of-two deep circular buffer with a combinational head.
// Assumes DEPTH is a power of two. A push while full is dropped, a pop while
// empty is ignored, and clear takes priority over both.
module adcseq_fifo
    import adcseq_pkg::*;
#(
    parameter  int DEPTH = 1024,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                push,
    input  logic [SAMPLE_W-1:0] push_data,
    input  logic                pop,
    output logic [SAMPLE_W-1:0] head,
    output logic                empty,
    output logic                full
);

    logic [SAMPLE_W-1:0] mem [DEPTH];
    logic [AW-1:0]       wr_ptr, rd_ptr;
    logic [AW:0]         count;
    logic                do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == (AW+1)'(DEPTH));
    assign do_push = push && !full && !clear;
    assign do_pop  = pop && !empty && !clear;
    assign head    = mem[rd_ptr];

    // Storage write; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
        end
    end

    // R11: a push into a full queue without a pop leaves it full.
    a_r11_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clear) |=> full);

    // R7: a pop on an empty queue with no push leaves it empty.
    a_r7_pop_empty_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);

endmodule

// File: rtl/adcseq_seq.sv
// Conversion sequencer: accepts a trigger when idle and settled, then walks
// channels lower..stop, pulsing the converter start and storing each sample
// CONV_CYCLES cycles later. Assumes CONV_CYCLES >= 1.
module adcseq_seq
    import adcseq_pkg::*;
#(
    parameter  int CHAN_W      = 5,
    parameter  int CONV_CYCLES = 4,
    localparam int CNT_W       = $clog2(CONV_CYCLES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                trigger,
    input  logic                settling,
    input  logic                scan_en,
    input  logic [CHAN_W-1:0]   chan_lo,
    input  logic [CHAN_W-1:0]   chan_hi,
    input  logic [SAMPLE_W-1:0] adc_sample,
    output logic                adc_start,
    output logic [CHAN_W-1:0]   adc_chan,
    output logic                busy,
    output logic                push,
    output logic [SAMPLE_W-1:0] push_data,
    output logic                scan_done
);

    seq_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [CHAN_W-1:0] cur, stop;
    logic              start_q;
    logic              accept;

    assign accept    = (state == SEQ_IDLE) && trigger && !settling;
    assign busy      = (state == SEQ_CONV);
    assign push      = busy && (cnt == CNT_W'(CONV_CYCLES - 1));
    assign push_data = adc_sample;
    assign scan_done = push && (cur == stop);
    assign adc_chan  = cur;
    assign adc_start = start_q;

    // Channel walk and conversion timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            cnt     <= '0;
            cur     <= '0;
            stop    <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (accept) begin
                        state   <= SEQ_CONV;
                        cur     <= chan_lo;
                        stop    <= (scan_en && (chan_hi > chan_lo)) ? chan_hi : chan_lo;
                        cnt     <= '0;
                        start_q <= 1'b1;
                    end
                end
                SEQ_CONV: begin
                    if (push) begin
                        cnt <= '0;
                        if (cur == stop) begin
                            state <= SEQ_IDLE;
                        end else begin
                            cur     <= cur + 1'b1;
                            start_q <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // R6: within a scan, the next conversion is on the next channel up.
    a_r6_ascending_step: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !scan_done) |=> (adc_chan == CHAN_W'($past(adc_chan) + 1'b1)));

    // R3: busy stays high until the final result of the scan is stored.
    a_r3_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !scan_done) |=> busy);

    // R8: no conversion starts while the analog path is settling.
    a_r8_settle_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && settling) |=> !busy);

    // R6: every conversion begins with a start pulse.
    a_r6_start_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> adc_start);

endmodule

// File: rtl/adcseq_regs.sv
// Register bank: bound, configuration, queue-control and interrupt registers,
// the settling timer, trigger qualification and the read-data multiplexer.
// Assumes a combinational read of bus_addr; only a strobed read of the
// high data byte has a side effect (the pop).
module adcseq_regs
    import adcseq_pkg::*;
#(
    parameter  int CHAN_W    = 5,
    parameter  int US_CYCLES = 2,
    localparam int SET_W     = $clog2(20 * US_CYCLES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [3:0]          addr,
    input  logic [7:0]          wdata,
    input  logic                pace_tick,
    input  logic                conv_busy,
    input  logic                scan_done,
    input  logic                q_empty,
    input  logic                q_full,
    input  logic [SAMPLE_W-1:0] q_head,
    output logic [7:0]          rdata,
    output logic [CHAN_W-1:0]   chan_lo,
    output logic [CHAN_W-1:0]   chan_hi,
    output logic                scan_en,
    output logic                settling,
    output logic                trigger,
    output logic                q_clear,
    output logic                q_pop,
    output logic                irq
);

    logic [5:0]       cfg_q;
    logic             int_en_q, int_pend_q;
    logic [1:0]       pace_sel_q;
    logic [SET_W-1:0] settle_q;
    logic             wr_bound, wr_cfg, wr_ctrl;
    logic [1:0]       next_sel;

    assign wr_bound = wr_en && ((addr == OFS_CHAN_LO) || (addr == OFS_CHAN_HI));
    assign wr_cfg   = wr_en && (addr == OFS_CFG);
    assign wr_ctrl  = wr_en && (addr == OFS_CTRL);
    assign next_sel = wr_cfg ? wdata[5:4] : cfg_q[5:4];
    assign settling = (settle_q != '0);
    assign trigger  = (wr_en && (addr == OFS_DATA_LO)) || (pace_tick && (pace_sel_q != 2'b00));
    assign q_clear  = wr_en && (addr == OFS_QUEUE) && wdata[1];
    assign q_pop    = rd_en && (addr == OFS_DATA_HI) && !q_empty;
    assign irq      = int_pend_q;

    // Host-writable configuration fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_lo    <= '0;
            chan_hi    <= '0;
            cfg_q      <= '0;
            scan_en    <= 1'b0;
            int_en_q   <= 1'b0;
            pace_sel_q <= 2'b00;
        end else if (wr_en) begin
            case (addr)
                OFS_CHAN_LO: chan_lo <= wdata[CHAN_W-1:0];
                OFS_CHAN_HI: chan_hi <= wdata[CHAN_W-1:0];
                OFS_CFG:     cfg_q   <= wdata[5:0];
                OFS_QUEUE:   scan_en <= wdata[2];
                OFS_IRQ: begin
                    int_en_q   <= wdata[7];
                    pace_sel_q <= wdata[1:0];
                end
                default: ;
            endcase
        end
    end

    // Settling timer, restarted by any bound or configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            settle_q <= '0;
        end else if (wr_bound || wr_cfg) begin
            settle_q <= SET_W'(settle_len(next_sel, US_CYCLES));
        end else if (settling) begin
            settle_q <= settle_q - 1'b1;
        end
    end

    // End-of-scan pending flag; a new event wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_pend_q <= 1'b0;
        end else if (scan_done && int_en_q) begin
            int_pend_q <= 1'b1;
        end else if (wr_ctrl && wdata[3]) begin
            int_pend_q <= 1'b0;
        end
    end

    // Read-data multiplexer.
    always_comb begin
        rdata = 8'h00;
        case (addr)
            OFS_DATA_LO: rdata = q_empty ? 8'h00 : q_head[7:0];
            OFS_DATA_HI: rdata = q_empty ? 8'h00 : q_head[15:8];
            OFS_CHAN_LO: rdata = 8'(chan_lo);
            OFS_CHAN_HI: rdata = 8'(chan_hi);
            OFS_QUEUE:   rdata = {q_empty, q_full, 3'b000, scan_en, 2'b00};
            OFS_CTRL:    rdata = {conv_busy, cfg_q[2], cfg_q[3], 5'b00000};
            OFS_IRQ:     rdata = {int_pend_q, 5'b00000, pace_sel_q};
            OFS_CFG:     rdata = {settling, 1'b0, cfg_q};
            default:     rdata = 8'h00;
        endcase
    end

    // R4: any bound or configuration write raises the settling flag.
    a_r4_settle_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_bound || wr_cfg) |=> settling);

    // R9: an enabled scan completion leaves the interrupt pending.
    a_r9_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_done && int_en_q) |=> irq);

    // R9: a clear with no competing event drops the interrupt.
    a_r9_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[3] && !(scan_done && int_en_q)) |=> !irq);

    // R10: with the pace select at 00, a tick alone is not a trigger.
    a_r10_pace_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (pace_sel_q == 2'b00 && !wr_en) |-> !trigger);

endmodule

// File: rtl/adcseq_front.sv
// Top of the scanning converter front-end: joins the register bank, the
// sequencer and the result queue, and derives the soft board reset.
// Assumes a single clock domain and a converter whose result is valid
// CONV_CYCLES cycles after its start pulse.
module adcseq_front
    import adcseq_pkg::*;
#(
    parameter  int CHAN_W      = 5,
    parameter  int CONV_CYCLES = 4,
    parameter  int US_CYCLES   = 2,
    parameter  int FIFO_DEPTH  = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [3:0]          bus_addr,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    input  logic                pace_tick,
    output logic                adc_start,
    output logic [CHAN_W-1:0]   adc_chan,
    input  logic [SAMPLE_W-1:0] adc_sample,
    output logic                irq
);

    logic                soft_rst, blk_rst_n;
    logic [CHAN_W-1:0]   chan_lo, chan_hi;
    logic                scan_en, settling, trigger;
    logic                q_clear, q_pop, q_empty, q_full;
    logic [SAMPLE_W-1:0] q_head, push_data;
    logic                conv_busy, push, scan_done;

    assign soft_rst  = bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[5];
    assign blk_rst_n = rst_n && !soft_rst;

    adcseq_regs #(
        .CHAN_W    (CHAN_W),
        .US_CYCLES (US_CYCLES)
    ) u_regs (
        .clk       (clk),
        .rst_n     (blk_rst_n),
        .wr_en     (bus_wr),
        .rd_en     (bus_rd),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .pace_tick (pace_tick),
        .conv_busy (conv_busy),
        .scan_done (scan_done),
        .q_empty   (q_empty),
        .q_full    (q_full),
        .q_head    (q_head),
        .rdata     (bus_rdata),
        .chan_lo   (chan_lo),
        .chan_hi   (chan_hi),
        .scan_en   (scan_en),
        .settling  (settling),
        .trigger   (trigger),
        .q_clear   (q_clear),
        .q_pop     (q_pop),
        .irq       (irq)
    );

    adcseq_seq #(
        .CHAN_W      (CHAN_W),
        .CONV_CYCLES (CONV_CYCLES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (blk_rst_n),
        .trigger    (trigger),
        .settling   (settling),
        .scan_en    (scan_en),
        .chan_lo    (chan_lo),
        .chan_hi    (chan_hi),
        .adc_sample (adc_sample),
        .adc_start  (adc_start),
        .adc_chan   (adc_chan),
        .busy       (conv_busy),
        .push       (push),
        .push_data  (push_data),
        .scan_done  (scan_done)
    );

    adcseq_fifo #(
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (blk_rst_n),
        .clear     (q_clear),
        .push      (push),
        .push_data (push_data),
        .pop       (q_pop),
        .head      (q_head),
        .empty     (q_empty),
        .full      (q_full)
    );

    // R13: a soft reset leaves the queue empty and the sequencer idle.
    a_r13_soft_reset: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (q_empty && !conv_busy && !irq));

endmodule

// File: tb/adcseq_front_bench.sv
`timescale 1ns/1ps
module adcseq_front_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = 4'h0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        pace_tick = 1'b0;
    logic        adc_start;
    logic [4:0]  adc_chan;
    logic [15:0] adc_sample;
    logic        irq;
    logic [15:0] seed = 16'h1234;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2 clk = ~clk;

    // Converter model: the value depends on the selected channel.
    assign adc_sample = seed + 16'(adc_chan) * 16'h0851;

    adcseq_front u_adcseq_front (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pace_tick(pace_tick), .adc_start(adc_start), .adc_chan(adc_chan),
        .adc_sample(adc_sample), .irq(irq)
    );

    function automatic logic [15:0] expect_word(input int ch);
        return seed + 16'(ch) * 16'h0851;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] s, c;
        for (int i = 0; i < 4000; i++) begin
            peek(4'h8, s);
            peek(4'hB, c);
            if (!s[7] && !c[7]) break;
            @(negedge clk);
        end
    endtask

    task automatic pop_word(output logic [15:0] w);
        logic [7:0] lo, hi;
        rd(4'h0, lo);
        rd(4'h1, hi);
        w = {hi, lo};
    endtask

    task automatic run_scan(input int lo, input int hi, input string req);
        logic [15:0] w;
        logic [7:0]  st;
        int n;
        n = (hi > lo) ? hi - lo + 1 : 1;
        wr(4'h2, 8'(lo));
        wr(4'h3, 8'(hi));
        wait_idle();
        wr(4'h0, 8'h00);
        wait_idle();
        for (int i = 0; i < n; i++) begin
            pop_word(w);
            chk(req, w, expect_word(lo + i));
        end
        peek(4'h7, st);
        chk(req, st[7], 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        logic [15:0] w;
        int          n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset readback
        peek(4'h7, d); chk("R1 queue status", d, 8'h80);
        peek(4'h8, d); chk("R1 status", d, 8'h00);
        peek(4'h9, d); chk("R1 irq reg", d, 8'h00);
        peek(4'hB, d); chk("R1 cfg", d, 8'h00);
        chk("R1 irq pin", irq, 1'b0);

        // R2 / R3 probe sequence
        wr(4'h2, 8'h80);
        wr(4'h3, 8'hFF);
        wr(4'hB, 8'h0C);
        wait_idle();
        peek(4'h2, d); chk("R2 lower bound", d, 8'h00);
        peek(4'h3, d); chk("R2 upper bound", d, 8'h1F);
        peek(4'h8, d); chk("R3 status after 0x0C", d, 8'h60);
        peek(4'h7, d); chk("R1 queue after probe", d, 8'h80);
        peek(4'hB, d); chk("R4 cfg readback", d, 8'h0C);

        // R4 settle length for every select value
        for (int s = 0; s < 4; s++) begin
            n = (20 - 5 * s) * 2;
            wr(4'hB, 8'({s[1:0], 4'hC}));
            peek(4'hB, d); chk("R4 settle raised", d[7], 1'b1);
            repeat (n - 1) @(negedge clk);
            peek(4'hB, d); chk("R4 settle last busy cycle", d[7], 1'b1);
            @(negedge clk);
            peek(4'hB, d); chk("R4 settle cleared", d, 8'(((s & 3) << 4) | 12));
        end

        // R5 single mode over every channel, upper bound held at 31
        wr(4'h3, 8'd31);
        for (int ch = 0; ch < 32; ch++) begin
            wr(4'h2, 8'(ch));
            wait_idle();
            wr(4'h0, 8'h5A);
            peek(4'h8, d); chk("R3 busy after trigger", d[7], 1'b1);
            wait_idle();
            pop_word(w); chk("R5 single channel word", w, expect_word(ch));
            peek(4'h7, d); chk("R5 exactly one word", d, 8'h80);
        end

        // R6 scan windows
        wr(4'h7, 8'h04);
        peek(4'h7, d); chk("R12 scan enable readback", d, 8'h84);
        run_scan(0, 31, "R6 full scan");
        run_scan(5, 9, "R6 middle span");
        run_scan(12, 12, "R6 equal bounds");
        run_scan(20, 3, "R6 reversed bounds");

        // R7 raw two's complement, sign bit untouched
        seed = 16'h8000;
        run_scan(0, 0, "R7 sign word");
        wr(4'h0, 8'h00);
        wait_idle();
        rd(4'h0, d); chk("R7 low byte", d, 8'h00);
        rd(4'h1, d); chk("R7 high byte keeps sign", d, 8'h80);
        rd(4'h1, d); chk("R7 empty read high", d, 8'h00);
        rd(4'h0, d); chk("R7 empty read low", d, 8'h00);
        seed = 16'h1234;

        // R8 trigger while busy
        wr(4'h2, 8'd2); wr(4'h3, 8'd4);
        wait_idle();
        wr(4'h0, 8'h00);
        wr(4'h0, 8'h00);
        wait_idle();
        for (int i = 0; i < 3; i++) begin
            pop_word(w); chk("R8 busy retrigger", w, expect_word(2 + i));
        end
        peek(4'h7, d); chk("R8 no extra scan", d[7], 1'b1);

        // R8 trigger while settling
        wr(4'h3, 8'd6);
        wr(4'h0, 8'h00);
        wait_idle();
        peek(4'h7, d); chk("R8 settle trigger ignored", d[7], 1'b1);

        // R9 interrupt
        wr(4'h9, 8'h80);
        wr(4'h2, 8'd3); wr(4'h3, 8'd6);
        wait_idle();
        wr(4'h0, 8'h00);
        chk("R9 irq low mid-scan", irq, 1'b0);
        wait_idle();
        chk("R9 irq after scan", irq, 1'b1);
        peek(4'h9, d); chk("R9 pending bit", d, 8'h80);
        wr(4'h8, 8'h08);
        chk("R9 irq cleared", irq, 1'b0);
        wr(4'h7, 8'h06);
        wr(4'h9, 8'h00);
        wr(4'h0, 8'h00);
        wait_idle();
        chk("R9 disabled no irq", irq, 1'b0);
        wr(4'h7, 8'h06);

        // R10 pacing
        wr(4'h2, 8'd7); wr(4'h3, 8'd7);
        wait_idle();
        @(negedge clk); pace_tick = 1'b1;
        @(negedge clk); pace_tick = 1'b0;
        wait_idle();
        peek(4'h7, d); chk("R10 tick ignored at select 00", d[7], 1'b1);
        wr(4'h9, 8'h01);
        @(negedge clk); pace_tick = 1'b1;
        @(negedge clk); pace_tick = 1'b0;
        wait_idle();
        pop_word(w); chk("R10 paced word", w, expect_word(7));
        wr(4'h9, 8'h00);

        // R11 fill to depth, overflow scan, drain
        wr(4'h2, 8'd0); wr(4'h3, 8'd31);
        wait_idle();
        for (int k = 0; k < 33; k++) begin
            wr(4'h0, 8'h00);
            wait_idle();
        end
        peek(4'h7, d); chk("R11 full status", d, 8'h44);
        for (int i = 0; i < 1024; i++) begin
            pop_word(w); chk("R11 drained word", w, expect_word(i % 32));
        end
        peek(4'h7, d); chk("R11 empty after drain", d, 8'h84);

        // R12 queue clear
        wr(4'h0, 8'h00);
        wait_idle();
        peek(4'h7, d); chk("R12 words present", d[7], 1'b0);
        wr(4'h7, 8'h02);
        peek(4'h7, d); chk("R12 cleared, scan off", d, 8'h80);

        // R13 soft reset
        wr(4'h9, 8'h81);
        wr(4'h0, 8'h00);
        wait_idle();
        wr(4'h8, 8'h20);
        peek(4'h2, d); chk("R13 lower bound", d, 8'h00);
        peek(4'h3, d); chk("R13 upper bound", d, 8'h00);
        peek(4'hB, d); chk("R13 cfg", d, 8'h00);
        peek(4'h9, d); chk("R13 irq reg", d, 8'h00);
        peek(4'h7, d); chk("R13 queue", d, 8'h80);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule